// File: doc/BRIEF.md
# Two-Channel DAC Simultaneous-Update Sequencer

This block sits on the host side of a two-channel serial DAC. It drives the converter over a three-wire SPI link: a serial clock, an active-low frame select and a data line. Its job is to make both analog outputs change at the same instant. The converter's hardware load strobe is held inactive at all times. Channel data is staged in the converter's input registers, and both outputs are then released by an update command sent as the last piece of an ordered burst.

After reset the sequencer waits for a start pulse. On that pulse it sends one initialisation frame, which powers the internal reference with a gain of two. From then on, each accepted update request carries a pair of 16-bit codes, and the sequencer emits the frames that load channel A, then load channel B, then release both outputs. A mode input picks between two forms of the burst. The long form uses three frames and ends with a separate update-all command. The short form uses two frames, and its second frame both loads channel B and updates both outputs. Requests that arrive too early or while a burst is in progress are dropped. `busy_o` and a one-cycle `done_o` pulse tell the host when the next request can be issued.

Top module: `dac_pair_sequencer`

## Requirements
- R1: `ldac_n_o` is 1 in every cycle, including during and right after reset.
- R2: Before the first start pulse no frame is sent. The first start pulse produces exactly one frame, 0x380001. Start pulses after that one have no effect.
- R3: An update request is taken only when the initialisation frame has completed and `busy_o` is 0. Requests at any other time produce no frames. An accepted request captures both codes and the mode bit on the accepting edge.
- R4: With `short_mode_i` = 0, an accepted request sends three frames in this order: {0x00, code A}, {0x01, code B}, 0x0F0000.
- R5: With `short_mode_i` = 1, an accepted request sends two frames in this order: {0xC0, code A}, {0xD1, code B}.
- R6: Each frame is 24 bits, sent most significant bit first. `sync_n_o` stays low across all 24 SCLK periods. SCLK idles low whenever `sync_n_o` is high. DIN changes only on a rising SCLK edge and is sampled on the falling edge.
- R7: Between two frames, `sync_n_o` stays high for at least two system clocks.
- R8: `done_o` is high for exactly one cycle, GAP_CYC+1 cycles after `sync_n_o` rises at the end of the final frame of a sequence (the initialisation counts as a sequence). At no other time is it high.
- R9: `busy_o` rises in the cycle after a request or the first start is accepted. It is high whenever `sync_n_o` is low, and it is low in the cycle `done_o` is high.
- R10: Every SCLK transition, and the rise of `sync_n_o` at the end of a frame, occurs HALF_DIV system clocks after the previous SCLK or `sync_n_o` transition within that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; the first one after reset sends the initialisation frame |
| upd_req_i | input | 1 | Request for a new pair of output codes |
| short_mode_i | input | 1 | 1 selects the two-frame burst, 0 the three-frame burst |
| code_a_i | input | 16 | Code for channel A |
| code_b_i | input | 16 | Code for channel B |
| sclk_o | output | 1 | Serial clock to the DAC |
| sync_n_o | output | 1 | Active-low frame select |
| din_o | output | 1 | Serial data, MSB first |
| ldac_n_o | output | 1 | Hardware load strobe, held inactive (high) |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench samples every output at the falling edge of the system clock. It decodes frames from the pins: it captures DIN at each observed SCLK fall, and it compares the 24 collected bits against a queue of expected frames when `sync_n_o` rises. That queue is filled at the moment a request or start is accepted. `done_o` is due exactly GAP_CYC+1 cycles after the `sync_n_o` rise that ends a sequence's last frame. `busy_o` is due one cycle after acceptance. Every SCLK or `sync_n_o` change within a frame is due HALF_DIV cycles after the previous one. The bench runs a per-cycle countdown and an interval counter, and checks each of these results in exactly the cycle it is due.

// File: rtl/dacseq_pkg.sv
// Shared constants, state types and frame builder for the DAC update sequencer.
// Assumes a 24-bit frame of an 8-bit command byte followed by a 16-bit code.
package dacseq_pkg;
    localparam int FRAME_W = 24;
    localparam int CODE_W  = 16;
    localparam int CMD_W   = FRAME_W - CODE_W;

    typedef enum logic [1:0] {C_WAIT, C_IDLE, C_LOAD, C_XFER} ctrl_st_t;
    typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_END, S_GAP} shift_st_t;

    localparam logic [FRAME_W-1:0] INIT_FRAME  = 24'h380001;
    localparam logic [FRAME_W-1:0] UPDATE_BOTH = 24'h0F0000;
    localparam logic [CMD_W-1:0]   LD_A_LONG   = 8'h00;
    localparam logic [CMD_W-1:0]   LD_B_LONG   = 8'h01;
    localparam logic [CMD_W-1:0]   LD_A_SHORT  = 8'hC0;
    localparam logic [CMD_W-1:0]   LD_B_SHORT  = 8'hD1;

    // Returns the frame for position idx of the current sequence.
    function automatic logic [FRAME_W-1:0] pick_frame(
        input logic              is_init,
        input logic              short_m,
        input logic [1:0]        idx,
        input logic [CODE_W-1:0] a,
        input logic [CODE_W-1:0] b
    );
        if (is_init) return INIT_FRAME;
        case (idx)
            2'd0:    return {(short_m ? LD_A_SHORT : LD_A_LONG), a};
            2'd1:    return {(short_m ? LD_B_SHORT : LD_B_LONG), b};
            default: return UPDATE_BOTH;
        endcase
    endfunction
endpackage

// File: rtl/dacseq_tick.sv
// Half-period tick generator for the serial clock.
// Emits a one-cycle tick every HALF_DIV clocks while enabled; clears when disabled.
module dacseq_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick_o = en_i && (cnt == CW'(HALF_DIV - 1));

    // Count system clocks within one SCLK half period.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (!en_i || tick_o)  cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dacseq_shifter.sv
// Serialises one 24-bit frame MSB first: SYNC_n low, 24 SCLK periods, SYNC_n high,
// then holds off GAP_CYC clocks before reporting completion on fdone_o.
// Assumes load_i is only raised while ready (idle).
module dacseq_shifter
    import dacseq_pkg::*;
#(
    parameter int GAP_CYC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               tick_i,
    output logic               tick_en_o,
    output logic               fdone_o,
    output logic               sclk_o,
    output logic               sync_n_o,
    output logic               din_o
);
    localparam int BW = $clog2(FRAME_W);
    localparam int GW = $clog2(GAP_CYC + 1);

    shift_st_t          st;
    logic [FRAME_W-1:0] sr;
    logic [BW-1:0]      bcnt;
    logic [GW-1:0]      gcnt;

    assign tick_en_o = (st == S_SHIFT) || (st == S_END);

    // Frame state machine: shift on SCLK rise, count bits on SCLK fall, then gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            sr       <= '0;
            bcnt     <= '0;
            gcnt     <= '0;
            sclk_o   <= 1'b0;
            sync_n_o <= 1'b1;
            din_o    <= 1'b0;
            fdone_o  <= 1'b0;
        end else begin
            fdone_o <= 1'b0;
            case (st)
                S_IDLE: if (load_i) begin
                    sr       <= frame_i;
                    bcnt     <= '0;
                    sclk_o   <= 1'b0;
                    sync_n_o <= 1'b0;
                    st       <= S_SHIFT;
                end
                S_SHIFT: if (tick_i) begin
                    if (!sclk_o) begin
                        sclk_o <= 1'b1;
                        din_o  <= sr[FRAME_W-1];
                        sr     <= {sr[FRAME_W-2:0], 1'b0};
                    end else begin
                        sclk_o <= 1'b0;
                        if (bcnt == BW'(FRAME_W - 1)) st <= S_END;
                        else                          bcnt <= bcnt + 1'b1;
                    end
                end
                S_END: if (tick_i) begin
                    sync_n_o <= 1'b1;
                    gcnt     <= '0;
                    st       <= S_GAP;
                end
                default: begin
                    if (gcnt == GW'(GAP_CYC - 1)) begin
                        fdone_o <= 1'b1;
                        st      <= S_IDLE;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dacseq_ctrl.sv
// Sequence controller: waits for the first start, sends the initialisation frame,
// then turns each accepted request into a two- or three-frame burst.
// Assumes fdone_i pulses once per frame loaded through load_o.
module dacseq_ctrl
    import dacseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               req_i,
    input  logic               short_i,
    input  logic [CODE_W-1:0]  code_a_i,
    input  logic [CODE_W-1:0]  code_b_i,
    input  logic               fdone_i,
    output logic               load_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               busy_o,
    output logic               done_o
);
    ctrl_st_t          st;
    logic              init_q;
    logic              short_q;
    logic [1:0]        idx;
    logic [1:0]        last_idx;
    logic [CODE_W-1:0] a_q;
    logic [CODE_W-1:0] b_q;

    assign last_idx = init_q ? 2'd0 : (short_q ? 2'd1 : 2'd2);
    assign load_o   = (st == C_LOAD);
    assign busy_o   = (st == C_LOAD) || (st == C_XFER);
    assign frame_o  = pick_frame(init_q, short_q, idx, a_q, b_q);

    // Sequence state: accept start/request, step through frames, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= C_WAIT;
            init_q  <= 1'b0;
            short_q <= 1'b0;
            idx     <= '0;
            a_q     <= '0;
            b_q     <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st)
                C_WAIT: if (start_i) begin
                    init_q <= 1'b1;
                    idx    <= '0;
                    st     <= C_LOAD;
                end
                C_IDLE: if (req_i) begin
                    init_q  <= 1'b0;
                    short_q <= short_i;
                    a_q     <= code_a_i;
                    b_q     <= code_b_i;
                    idx     <= '0;
                    st      <= C_LOAD;
                end
                C_LOAD: st <= C_XFER;
                default: if (fdone_i) begin
                    if (idx == last_idx) begin
                        done_o <= 1'b1;
                        st     <= C_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= C_LOAD;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dac_pair_sequencer.sv
// Top level: drives a two-channel serial DAC so both outputs change together.
// The hardware load strobe stays inactive; outputs are released by command only.
module dac_pair_sequencer
    import dacseq_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int GAP_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              upd_req_i,
    input  logic              short_mode_i,
    input  logic [CODE_W-1:0] code_a_i,
    input  logic [CODE_W-1:0] code_b_i,
    output logic              sclk_o,
    output logic              sync_n_o,
    output logic              din_o,
    output logic              ldac_n_o,
    output logic              busy_o,
    output logic              done_o
);
    logic               load;
    logic [FRAME_W-1:0] frame;
    logic               fdone;
    logic               tick;
    logic               tick_en;

    assign ldac_n_o = 1'b1;

    dacseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .req_i    (upd_req_i),
        .short_i  (short_mode_i),
        .code_a_i (code_a_i),
        .code_b_i (code_b_i),
        .fdone_i  (fdone),
        .load_o   (load),
        .frame_o  (frame),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    dacseq_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .tick_o (tick)
    );

    dacseq_shifter #(.GAP_CYC(GAP_CYC)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .frame_i   (frame),
        .tick_i    (tick),
        .tick_en_o (tick_en),
        .fdone_o   (fdone),
        .sclk_o    (sclk_o),
        .sync_n_o  (sync_n_o),
        .din_o     (din_o)
    );
endmodule

// File: rtl/dacseq_chk.sv
// Protocol checker for the DAC update sequencer, bound to the top module.
module dacseq_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic sync_n,
    input logic din,
    input logic busy,
    input logic done
);
    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |-> !sclk);
    // R6
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && !$rose(sclk)) |-> $stable(din));
    // R7
    sync_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |=> sync_n);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sync_n && !busy));
    // R9
    busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |-> busy);
endmodule

bind dac_pair_sequencer dacseq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk   (sclk_o),
    .sync_n (sync_n_o),
    .din    (din_o),
    .busy   (busy_o),
    .done   (done_o)
);

// File: tb/dac_pair_sequencer_tb.sv
module dac_pair_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int GAP        = 2;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, req = 1'b0, short_m = 1'b0;
    logic [15:0] code_a = '0, code_b = '0;
    logic sclk, sync_n, din, ldac_n, busy, done;

    dac_pair_sequencer #(.HALF_DIV(HALF), .GAP_CYC(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .upd_req_i(req),
        .short_mode_i(short_m), .code_a_i(code_a), .code_b_i(code_b),
        .sclk_o(sclk), .sync_n_o(sync_n), .din_o(din), .ldac_n_o(ldac_n),
        .busy_o(busy), .done_o(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    logic [23:0] exp_q[$];
    bit          last_q[$];
    string       tag_q[$];
    bit started = 0, inited = 0;
    int cd = 0, nbits = 0, since = 0;
    logic [23:0] shv = '0;
    logic prev_sclk = 1'b0, prev_sync = 1'b1;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic void push(input logic [23:0] f, input bit l, input string t);
        exp_q.push_back(f); last_q.push_back(l); tag_q.push_back(t);
    endfunction

    // Per-cycle reference model and pin decoder.
    always @(negedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL R8 watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (rst_n) begin
            bit exp_d;
            check(ldac_n == 1'b1, "R1", "ldac_n", ldac_n, 1);
            if (sync_n) check(!sclk, "R6", "sclk idle", sclk, 0);
            else        check(busy, "R9", "busy in frame", busy, 1);
            exp_d = (cd == 1);
            if (cd > 0) cd--;
            check(done == exp_d, "R8", "done", done, exp_d);
            if (exp_d) begin
                check(!busy, "R9", "busy at done", busy, 0);
                inited = 1;
            end
            since++;
            if (prev_sync && !sync_n) begin
                nbits = 0; shv = '0; since = 0;
            end else if ((sclk != prev_sclk) || (sync_n && !prev_sync)) begin
                check(since == HALF, "R10", "edge spacing", since, HALF);
                since = 0;
            end
            if (!sync_n && prev_sclk && !sclk) begin
                shv = {shv[22:0], din};
                nbits++;
            end
            if (sync_n && !prev_sync) begin
                check(nbits == 24, "R6", "bit count", nbits, 24);
                if (exp_q.size() == 0) begin
                    check(0, "R3", "unexpected frame", shv, 0);
                end else begin
                    logic [23:0] ef;
                    bit el;
                    string et;
                    ef = exp_q.pop_front(); el = last_q.pop_front(); et = tag_q.pop_front();
                    check(shv == ef, et, "frame", shv, ef);
                    if (el) cd = GAP + 1;
                end
            end
        end
        prev_sclk = sclk;
        prev_sync = sync_n;
    end

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        if (!started) begin
            started = 1;
            push(24'h380001, 1, "R2");
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_req(input logic [15:0] a, input logic [15:0] b, input logic sh);
        bit acc;
        @(negedge clk);
        req = 1'b1; code_a = a; code_b = b; short_m = sh;
        acc = inited && !busy;
        if (acc) begin
            if (sh) begin
                push({8'hC0, a}, 0, "R5");
                push({8'hD1, b}, 1, "R5");
            end else begin
                push({8'h00, a}, 0, "R4");
                push({8'h01, b}, 0, "R4");
                push(24'h0F0000, 1, "R4");
            end
        end
        @(negedge clk);
        req = 1'b0; code_a = ~a; code_b = ~b; short_m = ~sh;
        if (acc) check(busy == 1'b1, "R9", "busy after accept", busy, 1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && cd == 0 && !busy) return;
        end
        check(0, "R8", "sequence did not finish", exp_q.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(sync_n == 1'b1 && sclk == 1'b0, "R6", "reset pins", {sync_n, sclk}, 2'b10);
        check(busy == 1'b0 && done == 1'b0, "R9", "reset status", {busy, done}, 0);
        check(ldac_n == 1'b1, "R1", "ldac in reset", ldac_n, 1);
        rst_n = 1'b1;
        // R3: request before start is dropped
        do_req(16'h1234, 16'h5678, 1'b0);
        repeat (60) @(negedge clk);
        check(sync_n && !busy, "R2", "idle before start", {sync_n, busy}, 2'b10);
        do_start();
        check(busy == 1'b1, "R9", "busy after start", busy, 1);
        wait_idle();
        // R2: second start has no effect
        do_start();
        repeat (100) @(negedge clk);
        check(!busy && sync_n, "R2", "second start ignored", {busy, sync_n}, 2'b01);
        // R4 with a request and a start arriving while busy (R3)
        do_req(16'hA5C3, 16'h3C5A, 1'b0);
        repeat (20) @(negedge clk);
        do_req(16'h1111, 16'h2222, 1'b1);
        do_start();
        wait_idle();
        do_req(16'hFFFF, 16'h0000, 1'b1);
        wait_idle();
        do_req(16'h0000, 16'hFFFF, 1'b0);
        wait_idle();
        do_req(16'h8001, 16'h7FFE, 1'b1);
        repeat (30) @(negedge clk);
        do_req(16'hDEAD, 16'hBEEF, 1'b0);
        wait_idle();
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R3", "all expected frames sent", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule